// File: doc/BRIEF.md
# Row Tag-Block Lookup Cache

This block is a small on-chip store placed ahead of a large DRAM cache that keeps its own tags in DRAM. Each entry caches the complete set of tag blocks for one DRAM row: eight blocks, each holding seven line tags. A lookup can therefore tell whether the DRAM cache holds a line without a DRAM access and without a query to the presence directory. The store is organised as 32 sets of 4 ways. A block address splits, from the least significant bit up, into a 3-bit block select, a 5-bit set index, a 12-bit row tag and a 28-bit line tag.

A lookup first checks all ways of the indexed set against the row tag. On a row hit, it then compares the line tag against the seven slots of the selected tag block. It reports whether the row was present, whether a line matched, and which slot matched. Two write paths keep the contents current. A fill installs a whole row's eight blocks. An update rewrites one block of a row that is already resident and marks that entry dirty. If a fill evicts a dirty entry, the block raises a write-back request carrying the victim's set index and row tag. That request stays up until the requester acknowledges it.

Top module: `tag_block_cache`

## Requirements
- R1: A lookup is issued on `lkValid`. Its results appear with `resValid` high for exactly one cycle, two clock edges after the edge that sampled the lookup, and `resValid` is low at the first of those edges. At most one of `lkValid`, `fillValid` and `updValid` is high in a cycle.
- R2: `resRowHit` is 1 exactly when some valid way of the set selected by address bits [7:3] holds the row tag in bits [19:8]. All ways are compared at once, and every set index from 0 to 31 works.
- R3: On a row hit, the tag block named by bits [2:0] is searched. Slot l occupies bits [l*29 +: 29] of the block, with bit 28 as its valid flag and bits [27:0] as its line tag. `resLineHit` is 1 when some valid slot's tag equals address bits [47:20]. `resLine` gives the lowest such slot and is 0 when no slot matches. A slot whose valid flag is 0 never matches, even if its tag is equal.
- R4: On a row miss, `resLineHit` and `resLine` are 0.
- R5: A fill whose row is already resident rewrites that same way, which leaves the entry clean and evicts nothing. Any other fill takes the lowest-numbered invalid way, or the least recently used way when the set is full. Block b of `fillRow` occupies bits [b*203 +: 203].
- R6: A lookup that hits and an accepted fill both make their way the most recently used. An update leaves the recency order unchanged.
- R7: An update to a resident row replaces only block [2:0] of that entry and sets the entry dirty. An update to a row that is not resident has no effect.
- R8: When a fill evicts a dirty entry, `wbValid` rises at the fill's edge, with `wbIdx` and `wbRowTag` set to the victim's index and row tag. These hold steady until `wbAck` is seen. While `wbValid` is high, `fillReady` is 0 and any fill presented is ignored.
- R9: Evicting a clean entry raises no write-back.
- R10: After reset, every entry is invalid, `wbValid` and `resValid` are 0, and `fillReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup strobe |
| lkAddr | input | 48 | Lookup block address |
| fillValid | input | 1 | Fill strobe |
| fillAddr | input | 48 | Fill row address (bits [2:0] unused by the fill) |
| fillRow | input | 1624 | Eight tag blocks for the filled row |
| fillReady | output | 1 | Fills are accepted |
| updValid | input | 1 | Block update strobe |
| updAddr | input | 48 | Update address, with bits [2:0] selecting the block |
| updBlock | input | 203 | New tag-block contents |
| resValid | output | 1 | Lookup result valid |
| resRowHit | output | 1 | Row tags present |
| resLineHit | output | 1 | Line tag found in the block |
| resLine | output | 3 | Matching slot number |
| wbValid | output | 1 | Write-back request for a dirty victim |
| wbIdx | output | 5 | Victim set index |
| wbRowTag | output | 12 | Victim row tag |
| wbAck | input | 1 | Write-back acknowledge |

## Verification
The bench builds the block with its default parameters: 32 sets, 4 ways, 8 blocks of 7 slots, a 12-bit row tag and a 28-bit line tag. With four ways, a fifth and sixth distinct row in one set force replacements. The order in which rows vanish then exposes the recency tracking, and a dirty victim can be forced out to exercise the write-back hold. Seven slots per block allow a duplicate tag to test lowest-slot priority next to an invalid slot. The two ends of the index range, 0 and 31, together with block 7 and slot 6, reach the extreme field positions.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  // Strobes from control to datapath, one operation per cycle
  typedef struct packed {
    logic touch;       // promote the selected way to most recently used
    logic writeEntry;  // install a full row into the selected way
    logic writeBlock;  // replace one tag block and mark the entry dirty
  } tbcStrobe_t;
endpackage

// File: rtl/tbc_datapath.sv
module tbc_datapath
  import tbc_pkg::*;
#(
  parameter int SETS       = 32,
  parameter int WAYS       = 4,
  parameter int BLOCKS     = 8,
  parameter int LINES      = 7,
  parameter int ROW_TAG_W  = 12,
  parameter int LINE_TAG_W = 28,
  localparam int IDX_W      = $clog2(SETS),
  localparam int WAY_W      = $clog2(WAYS),
  localparam int AGE_W      = WAY_W,
  localparam int SEL_W      = $clog2(BLOCKS),
  localparam int LINE_SEL_W = $clog2(LINES),
  localparam int SLOT_W     = LINE_TAG_W + 1,
  localparam int BLK_W      = LINES * SLOT_W,
  localparam int ROW_W      = BLOCKS * BLK_W,
  localparam int ADDR_W     = LINE_TAG_W + ROW_TAG_W + IDX_W + SEL_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lkValid,
  input  logic [ADDR_W-1:0]         opAddr,
  input  logic [ROW_W-1:0]          fillRow,
  input  logic [BLK_W-1:0]          updBlock,
  input  tbcStrobe_t                strb,
  input  logic [WAY_W-1:0]          ctlWay,
  output logic [WAYS-1:0]           hitVec,
  output logic [WAYS-1:0]           validVec,
  output logic [WAYS-1:0]           dirtyVec,
  output logic [WAYS*AGE_W-1:0]     ageVec,
  output logic [WAYS*ROW_TAG_W-1:0] setTags,
  output logic [IDX_W-1:0]          opIdx,
  output logic                      resValid,
  output logic                      resRowHit,
  output logic                      resLineHit,
  output logic [LINE_SEL_W-1:0]     resLine
);

  logic [SEL_W-1:0]      opSel;
  logic [ROW_TAG_W-1:0]  opRowTag;
  logic [LINE_TAG_W-1:0] opLineTag;

  assign opSel     = opAddr[SEL_W-1:0];
  assign opIdx     = opAddr[SEL_W +: IDX_W];
  assign opRowTag  = opAddr[SEL_W+IDX_W +: ROW_TAG_W];
  assign opLineTag = opAddr[ADDR_W-1 -: LINE_TAG_W];

  // Entry state
  logic                 validArr [SETS][WAYS];
  logic                 dirtyArr [SETS][WAYS];
  logic [AGE_W-1:0]     ageArr   [SETS][WAYS];
  logic [ROW_TAG_W-1:0] tagArr   [SETS][WAYS];
  logic [BLK_W-1:0]     payArr   [SETS][WAYS][BLOCKS];

  // Parallel row-tag compare over the indexed set
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hitVec[w]   = validArr[opIdx][w] && (tagArr[opIdx][w] == opRowTag);
    assign validVec[w] = validArr[opIdx][w];
    assign dirtyVec[w] = dirtyArr[opIdx][w];
    assign ageVec[w*AGE_W +: AGE_W]         = ageArr[opIdx][w];
    assign setTags[w*ROW_TAG_W +: ROW_TAG_W] = tagArr[opIdx][w];
  end

  logic [AGE_W-1:0] oldAge;
  assign oldAge = ageArr[opIdx][ctlWay];

  // Flags and recency; ages stay a permutation of 0..WAYS-1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          validArr[s][w] <= 1'b0;
          dirtyArr[s][w] <= 1'b0;
          ageArr[s][w]   <= AGE_W'(w);
        end
      end
    end else begin
      if (strb.writeEntry) begin
        validArr[opIdx][ctlWay] <= 1'b1;
        dirtyArr[opIdx][ctlWay] <= 1'b0;
      end
      if (strb.writeBlock) begin
        dirtyArr[opIdx][ctlWay] <= 1'b1;
      end
      if (strb.touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (ctlWay == WAY_W'(w)) begin
            ageArr[opIdx][w] <= '0;
          end else if (ageArr[opIdx][w] < oldAge) begin
            ageArr[opIdx][w] <= ageArr[opIdx][w] + 1'b1;
          end
        end
      end
    end
  end

  // Tag and payload storage, no reset
  always_ff @(posedge clk) begin
    if (strb.writeEntry) begin
      tagArr[opIdx][ctlWay] <= opRowTag;
      for (int b = 0; b < BLOCKS; b++) begin
        payArr[opIdx][ctlWay][b] <= fillRow[b*BLK_W +: BLK_W];
      end
    end
    if (strb.writeBlock) begin
      payArr[opIdx][ctlWay][opSel] <= updBlock;
    end
  end

  // Stage 1: row hit resolved, selected block captured
  logic                  s1Valid;
  logic                  s1RowHit;
  logic [BLK_W-1:0]      s1Block;
  logic [LINE_TAG_W-1:0] s1LineTag;

  // Stage 2 compare over the line slots
  logic                  lineHitC;
  logic [LINE_SEL_W-1:0] lineIdxC;

  always_comb begin
    lineHitC = 1'b0;
    lineIdxC = '0;
    for (int l = LINES - 1; l >= 0; l--) begin
      if (s1Block[l*SLOT_W + LINE_TAG_W] &&
          (s1Block[l*SLOT_W +: LINE_TAG_W] == s1LineTag)) begin
        lineHitC = 1'b1;
        lineIdxC = LINE_SEL_W'(l);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Valid    <= 1'b0;
      s1RowHit   <= 1'b0;
      s1Block    <= '0;
      s1LineTag  <= '0;
      resValid   <= 1'b0;
      resRowHit  <= 1'b0;
      resLineHit <= 1'b0;
      resLine    <= '0;
    end else begin
      s1Valid    <= lkValid;
      s1RowHit   <= |hitVec;
      s1Block    <= payArr[opIdx][ctlWay][opSel];
      s1LineTag  <= opLineTag;
      resValid   <= s1Valid;
      resRowHit  <= s1Valid && s1RowHit;
      resLineHit <= s1Valid && s1RowHit && lineHitC;
      resLine    <= (s1Valid && s1RowHit && lineHitC) ? lineIdxC : '0;
    end
  end

  logic [WAYS-1:0] ageMap;
  always_comb begin
    ageMap = '0;
    for (int w = 0; w < WAYS; w++) begin
      ageMap[ageArr[opIdx][w]] = 1'b1;
    end
  end

  AST_LRU_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    ageMap == {WAYS{1'b1}}); // R6
  AST_ROW_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitVec)); // R5
  AST_LINE_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    resLineHit |-> (resRowHit && resValid)); // R4

endmodule

// File: rtl/tbc_control.sv
module tbc_control
  import tbc_pkg::*;
#(
  parameter int SETS      = 32,
  parameter int WAYS      = 4,
  parameter int ROW_TAG_W = 12,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = WAY_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lkValid,
  input  logic                      fillValid,
  input  logic                      updValid,
  input  logic                      wbAck,
  input  logic [WAYS-1:0]           hitVec,
  input  logic [WAYS-1:0]           validVec,
  input  logic [WAYS-1:0]           dirtyVec,
  input  logic [WAYS*AGE_W-1:0]     ageVec,
  input  logic [WAYS*ROW_TAG_W-1:0] setTags,
  input  logic [IDX_W-1:0]          opIdx,
  output tbcStrobe_t                strb,
  output logic [WAY_W-1:0]          ctlWay,
  output logic                      fillReady,
  output logic                      wbValid,
  output logic [IDX_W-1:0]          wbIdx,
  output logic [ROW_TAG_W-1:0]      wbRowTag
);

  logic             hitAny, invAny, fillAcc, evictDirty;
  logic [WAY_W-1:0] hitWay, invWay, lruWay;

  // Lowest-index hit, lowest-index invalid, oldest way
  always_comb begin
    hitAny = 1'b0;
    invAny = 1'b0;
    hitWay = '0;
    invWay = '0;
    lruWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) begin
        hitAny = 1'b1;
        hitWay = WAY_W'(w);
      end
      if (!validVec[w]) begin
        invAny = 1'b1;
        invWay = WAY_W'(w);
      end
      if (ageVec[w*AGE_W +: AGE_W] == AGE_W'(WAYS - 1)) begin
        lruWay = WAY_W'(w);
      end
    end
  end

  assign fillReady  = !wbValid;
  assign fillAcc    = fillValid && !wbValid;
  assign evictDirty = fillAcc && !hitAny && !invAny && dirtyVec[lruWay];

  always_comb begin
    if (fillValid) begin
      ctlWay = hitAny ? hitWay : (invAny ? invWay : lruWay);
    end else begin
      ctlWay = hitWay;
    end
    strb.writeEntry = fillAcc;
    strb.writeBlock = updValid && hitAny;
    strb.touch      = fillAcc || (lkValid && hitAny);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbValid  <= 1'b0;
      wbIdx    <= '0;
      wbRowTag <= '0;
    end else if (evictDirty) begin
      wbValid  <= 1'b1;
      wbIdx    <= opIdx;
      wbRowTag <= setTags[int'(lruWay)*ROW_TAG_W +: ROW_TAG_W];
    end else if (wbAck) begin
      wbValid  <= 1'b0;
    end
  end

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wbValid && !wbAck) |=> (wbValid && $stable(wbIdx) && $stable(wbRowTag))); // R8
  AST_FILL_WHILE_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (fillValid && wbValid) |=> $stable(wbRowTag)); // R8

endmodule

// File: rtl/tag_block_cache.sv
module tag_block_cache
  import tbc_pkg::*;
#(
  parameter int SETS       = 32,
  parameter int WAYS       = 4,
  parameter int BLOCKS     = 8,
  parameter int LINES      = 7,
  parameter int ROW_TAG_W  = 12,
  parameter int LINE_TAG_W = 28,
  localparam int IDX_W      = $clog2(SETS),
  localparam int WAY_W      = $clog2(WAYS),
  localparam int AGE_W      = WAY_W,
  localparam int SEL_W      = $clog2(BLOCKS),
  localparam int LINE_SEL_W = $clog2(LINES),
  localparam int BLK_W      = LINES * (LINE_TAG_W + 1),
  localparam int ROW_W      = BLOCKS * BLK_W,
  localparam int ADDR_W     = LINE_TAG_W + ROW_TAG_W + IDX_W + SEL_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lkValid,
  input  logic [ADDR_W-1:0]     lkAddr,
  input  logic                  fillValid,
  input  logic [ADDR_W-1:0]     fillAddr,
  input  logic [ROW_W-1:0]      fillRow,
  output logic                  fillReady,
  input  logic                  updValid,
  input  logic [ADDR_W-1:0]     updAddr,
  input  logic [BLK_W-1:0]      updBlock,
  output logic                  resValid,
  output logic                  resRowHit,
  output logic                  resLineHit,
  output logic [LINE_SEL_W-1:0] resLine,
  output logic                  wbValid,
  output logic [IDX_W-1:0]      wbIdx,
  output logic [ROW_TAG_W-1:0]  wbRowTag,
  input  logic                  wbAck
);

  logic [ADDR_W-1:0]         opAddr;
  tbcStrobe_t                strb;
  logic [WAY_W-1:0]          ctlWay;
  logic [WAYS-1:0]           hitVec, validVec, dirtyVec;
  logic [WAYS*AGE_W-1:0]     ageVec;
  logic [WAYS*ROW_TAG_W-1:0] setTags;
  logic [IDX_W-1:0]          opIdx;

  // One shared address path; the caller presents one operation per cycle
  assign opAddr = fillValid ? fillAddr : (updValid ? updAddr : lkAddr);

  tbc_datapath #(
    .SETS(SETS), .WAYS(WAYS), .BLOCKS(BLOCKS), .LINES(LINES),
    .ROW_TAG_W(ROW_TAG_W), .LINE_TAG_W(LINE_TAG_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .lkValid(lkValid), .opAddr(opAddr),
    .fillRow(fillRow), .updBlock(updBlock), .strb(strb), .ctlWay(ctlWay),
    .hitVec(hitVec), .validVec(validVec), .dirtyVec(dirtyVec),
    .ageVec(ageVec), .setTags(setTags), .opIdx(opIdx),
    .resValid(resValid), .resRowHit(resRowHit),
    .resLineHit(resLineHit), .resLine(resLine)
  );

  tbc_control #(
    .SETS(SETS), .WAYS(WAYS), .ROW_TAG_W(ROW_TAG_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .lkValid(lkValid), .fillValid(fillValid),
    .updValid(updValid), .wbAck(wbAck), .hitVec(hitVec),
    .validVec(validVec), .dirtyVec(dirtyVec), .ageVec(ageVec),
    .setTags(setTags), .opIdx(opIdx), .strb(strb), .ctlWay(ctlWay),
    .fillReady(fillReady), .wbValid(wbValid), .wbIdx(wbIdx),
    .wbRowTag(wbRowTag)
  );

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lkValid, fillValid, updValid})); // R1
  AST_RES_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    lkValid |-> ##2 resValid); // R1

endmodule

// File: tb/tag_block_cache_test.sv
`timescale 1ns/1ps
module tag_block_cache_test;

  localparam int ADDR_W = 48;
  localparam int SLOT_W = 29;
  localparam int BLK_W  = 7 * SLOT_W;
  localparam int ROW_W  = 8 * BLK_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              lkValid, fillValid, updValid, wbAck;
  logic [ADDR_W-1:0] lkAddr, fillAddr, updAddr;
  logic [ROW_W-1:0]  fillRow;
  logic [BLK_W-1:0]  updBlock;
  logic              fillReady, resValid, resRowHit, resLineHit, wbValid;
  logic [2:0]        resLine;
  logic [4:0]        wbIdx;
  logic [11:0]       wbRowTag;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  tag_block_cache uut (
    .clk(clk), .rst_n(rst_n), .lkValid(lkValid), .lkAddr(lkAddr),
    .fillValid(fillValid), .fillAddr(fillAddr), .fillRow(fillRow),
    .fillReady(fillReady), .updValid(updValid), .updAddr(updAddr),
    .updBlock(updBlock), .resValid(resValid), .resRowHit(resRowHit),
    .resLineHit(resLineHit), .resLine(resLine), .wbValid(wbValid),
    .wbIdx(wbIdx), .wbRowTag(wbRowTag), .wbAck(wbAck)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [27:0] lt(input int seed, input int b, input int l);
    logic [19:0] s;
    s = seed[19:0];
    return {s, b[3:0], l[3:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] mkAddr(input logic [27:0] lineTag,
      input logic [11:0] rowTag, input logic [4:0] ix, input logic [2:0] sel);
    return {lineTag, rowTag, ix, sel};
  endfunction

  function automatic logic [ROW_W-1:0] mkRow(input int seed);
    logic [ROW_W-1:0] r;
    r = '0;
    for (int b = 0; b < 8; b++)
      for (int l = 0; l < 7; l++)
        r[b*BLK_W + l*SLOT_W +: SLOT_W] = {1'b1, lt(seed, b, l)};
    return r;
  endfunction

  task automatic doLookup(input string req, input logic [ADDR_W-1:0] a,
      input logic eRow, input logic eLine, input int eSlot);
    @(negedge clk); lkValid = 1'b1; lkAddr = a;
    @(negedge clk); lkValid = 1'b0;
    check(req, "resValid one edge after lookup", {31'd0, resValid}, 32'd0);
    @(negedge clk);
    check(req, "resValid", {31'd0, resValid}, 32'd1);
    check(req, "resRowHit", {31'd0, resRowHit}, {31'd0, eRow});
    check(req, "resLineHit", {31'd0, resLineHit}, {31'd0, eLine});
    check(req, "resLine", {29'd0, resLine}, eSlot[31:0]);
  endtask

  task automatic doFill(input logic [11:0] rt, input logic [4:0] ix, input int seed);
    @(negedge clk); fillValid = 1'b1; fillAddr = mkAddr(28'd0, rt, ix, 3'd0);
    fillRow = mkRow(seed);
    @(negedge clk); fillValid = 1'b0;
  endtask

  task automatic doUpd(input logic [ADDR_W-1:0] a, input logic [BLK_W-1:0] blk);
    @(negedge clk); updValid = 1'b1; updAddr = a; updBlock = blk;
    @(negedge clk); updValid = 1'b0;
  endtask

  task automatic doAck();
    @(negedge clk); wbAck = 1'b1;
    @(negedge clk); wbAck = 1'b0;
  endtask

  // R10
  task automatic testReset();
    check("R10", "wbValid after reset", {31'd0, wbValid}, 32'd0);
    check("R10", "resValid after reset", {31'd0, resValid}, 32'd0);
    check("R10", "fillReady after reset", {31'd0, fillReady}, 32'd1);
    doLookup("R10", mkAddr(lt(1, 3, 4), 12'h111, 5'd5, 3'd3), 1'b0, 1'b0, 0);
    doLookup("R10", mkAddr(28'd0, 12'h000, 5'd0, 3'd0), 1'b0, 1'b0, 0);
  endtask

  // R1 R2 R3 R4
  task automatic testBasic();
    doFill(12'h111, 5'd5, 1);
    doLookup("R1 R2 R3", mkAddr(lt(1, 3, 4), 12'h111, 5'd5, 3'd3), 1'b1, 1'b1, 4);
    doLookup("R3 no tag", mkAddr(28'hFFFFFFF, 12'h111, 5'd5, 3'd3), 1'b1, 1'b0, 0);
    doLookup("R3 other block", mkAddr(lt(1, 3, 4), 12'h111, 5'd5, 3'd4), 1'b1, 1'b0, 0);
    doLookup("R4 row miss", mkAddr(lt(1, 3, 4), 12'h112, 5'd5, 3'd3), 1'b0, 1'b0, 0);
    doLookup("R2 other set", mkAddr(lt(1, 3, 4), 12'h111, 5'd6, 3'd3), 1'b0, 1'b0, 0);
  endtask

  // R3 R7
  task automatic testUpdate();
    logic [BLK_W-1:0] blk;
    for (int l = 0; l < 7; l++) blk[l*SLOT_W +: SLOT_W] = {1'b1, lt(1, 2, l)};
    blk[0*SLOT_W +: SLOT_W] = {1'b0, 28'h1234567};
    blk[1*SLOT_W +: SLOT_W] = {1'b1, 28'hABCDEF1};
    blk[5*SLOT_W +: SLOT_W] = {1'b1, 28'hABCDEF1};
    doUpd(mkAddr(28'd0, 12'h111, 5'd5, 3'd2), blk);
    doLookup("R3 R7 lowest slot", mkAddr(28'hABCDEF1, 12'h111, 5'd5, 3'd2), 1'b1, 1'b1, 1);
    doLookup("R3 invalid slot", mkAddr(28'h1234567, 12'h111, 5'd5, 3'd2), 1'b1, 1'b0, 0);
    doLookup("R7 block 3 kept", mkAddr(lt(1, 3, 4), 12'h111, 5'd5, 3'd3), 1'b1, 1'b1, 4);
    doLookup("R7 old tag gone", mkAddr(lt(1, 2, 1), 12'h111, 5'd5, 3'd2), 1'b1, 1'b0, 0);
    doUpd(mkAddr(28'd0, 12'h222, 5'd5, 3'd2), blk);
    doLookup("R7 nonresident ignored", mkAddr(28'hABCDEF1, 12'h222, 5'd5, 3'd2), 1'b0, 1'b0, 0);
  endtask

  // R5 R6 R8 R9
  task automatic testReplace();
    doFill(12'h202, 5'd5, 2);
    doFill(12'h303, 5'd5, 3);
    doFill(12'h404, 5'd5, 4);
    check("R5", "no wb filling invalid ways", {31'd0, wbValid}, 32'd0);
    doLookup("R5 all four resident", mkAddr(lt(2, 0, 0), 12'h202, 5'd5, 3'd0), 1'b1, 1'b1, 0);
    // recency now: B newest, then D, C, A (A touched earlier than B fill)
    doLookup("R6 touch A", mkAddr(lt(1, 3, 4), 12'h111, 5'd5, 3'd3), 1'b1, 1'b1, 4);
    // order now A, B, D, C -> oldest C
    doFill(12'h505, 5'd5, 5);
    check("R9", "clean victim no wb", {31'd0, wbValid}, 32'd0);
    doLookup("R6 C evicted", mkAddr(lt(3, 0, 0), 12'h303, 5'd5, 3'd0), 1'b0, 1'b0, 0);
    doLookup("R6 D kept", mkAddr(lt(4, 0, 0), 12'h404, 5'd5, 3'd0), 1'b1, 1'b1, 0);
    // order D, E, A, B -> oldest B
    doFill(12'h606, 5'd5, 6);
    check("R9", "clean victim no wb 2", {31'd0, wbValid}, 32'd0);
    doLookup("R6 B evicted", mkAddr(lt(2, 0, 0), 12'h202, 5'd5, 3'd0), 1'b0, 1'b0, 0);
    // order F, D, E, A -> oldest A (dirty)
    doFill(12'h707, 5'd5, 7);
    check("R8", "wbValid on dirty victim", {31'd0, wbValid}, 32'd1);
    check("R8", "wbIdx", {27'd0, wbIdx}, 32'd5);
    check("R8", "wbRowTag", {20'd0, wbRowTag}, 32'h111);
    check("R8", "fillReady low", {31'd0, fillReady}, 32'd0);
    doFill(12'h808, 5'd5, 8);
    check("R8", "wb held", {31'd0, wbValid}, 32'd1);
    check("R8", "wbRowTag held", {20'd0, wbRowTag}, 32'h111);
    doLookup("R8 blocked fill ignored", mkAddr(lt(8, 0, 0), 12'h808, 5'd5, 3'd0), 1'b0, 1'b0, 0);
    doLookup("R8 A gone", mkAddr(lt(1, 3, 4), 12'h111, 5'd5, 3'd3), 1'b0, 1'b0, 0);
    check("R8", "wbIdx held", {27'd0, wbIdx}, 32'd5);
    doAck();
    check("R8", "wb cleared by ack", {31'd0, wbValid}, 32'd0);
    check("R8", "fillReady restored", {31'd0, fillReady}, 32'd1);
  endtask

  // R5 R9
  task automatic testRefill();
    doUpd(mkAddr(28'd0, 12'h505, 5'd5, 3'd0), '0);
    doFill(12'h505, 5'd5, 9);
    check("R5", "refill no wb", {31'd0, wbValid}, 32'd0);
    doLookup("R5 refilled in place", mkAddr(lt(9, 0, 2), 12'h505, 5'd5, 3'd0), 1'b1, 1'b1, 2);
    doLookup("R5 D still resident", mkAddr(lt(4, 1, 1), 12'h404, 5'd5, 3'd1), 1'b1, 1'b1, 1);
    doLookup("R5 F still resident", mkAddr(lt(6, 1, 1), 12'h606, 5'd5, 3'd1), 1'b1, 1'b1, 1);
    doLookup("R5 G still resident", mkAddr(lt(7, 7, 6), 12'h707, 5'd5, 3'd7), 1'b1, 1'b1, 6);
    for (int k = 0; k < 4; k++) begin
      doFill(12'h901 + 12'(k), 5'd5, 10 + k);
      check("R9", "refilled entry clean on eviction", {31'd0, wbValid}, 32'd0);
      if (wbValid) doAck();
    end
    doLookup("R6 old rows gone", mkAddr(lt(9, 0, 2), 12'h505, 5'd5, 3'd0), 1'b0, 1'b0, 0);
    doLookup("R6 new row present", mkAddr(lt(13, 2, 3), 12'h904, 5'd5, 3'd2), 1'b1, 1'b1, 3);
  endtask

  // R2 R3 boundaries
  task automatic testEdges();
    doFill(12'hABC, 5'd0, 20);
    doFill(12'hFFF, 5'd31, 21);
    doLookup("R2 index 0 block 7 slot 6", mkAddr(lt(20, 7, 6), 12'hABC, 5'd0, 3'd7), 1'b1, 1'b1, 6);
    doLookup("R2 index 31 slot 0", mkAddr(lt(21, 0, 0), 12'hFFF, 5'd31, 3'd0), 1'b1, 1'b1, 0);
    doLookup("R2 index 31 wrong tag", mkAddr(lt(21, 0, 0), 12'hABC, 5'd31, 3'd0), 1'b0, 1'b0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lkValid = 1'b0; fillValid = 1'b0; updValid = 1'b0; wbAck = 1'b0;
    lkAddr = '0; fillAddr = '0; updAddr = '0; fillRow = '0; updBlock = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testUpdate();
    testReplace();
    testRefill();
    testEdges();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule